// File: doc/BRIEF.md
# Floating-Point Context Frame Sequencer

This block saves and restores the internal-state frame of a floating-point unit. A save writes a frame of 32-bit words to memory through an address register. A restore reads a one-word header back and acts on it. A save command writes one of two frames. If the unit has not run any operation since it was reinitialised, it writes a single zero word, the empty frame. Otherwise it writes a seven-word idle frame. In postincrement mode the frame is laid out upward from the address. In predecrement mode it is laid out downward below the address. The updated address register value is returned when the command finishes.

A restore reads the header word. If the header's top byte is zero, the header marks an empty frame. The block then pulses a clear to the control, status and instruction-address registers, writes every data register with the not-a-number reset pattern, and sets the fresh flag. Any other header clears the fresh flag. In postincrement mode, the size code in the header moves the address register past the rest of the frame. Unsupported addressing modes end at once with an error.

Commands use a valid/ready handshake: a command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. Memory requests also use valid/ready. The block holds a request stable until `mem_req_ready` is high. It keeps only one request outstanding. A read response is taken when `mem_rsp_valid` and `mem_rsp_ready` are both high.

Top module: `fpctx_frame_ctrl`

## Requirements
- R1: After reset, `fresh` is 1, `cmd_ready` is 1, and `done_valid`, `mem_req_valid`, `rf_we` and `ctl_clear` are 0.
- R2: A save in postincrement mode (mode 2'b01) with `fresh` at 0 writes seven words upward from address A. The words are 0x1F180000 at A, zero at A+4 through A+20, and 0x70000000 at A+24. The result address is A+28.
- R3: A save in predecrement mode (mode 2'b10) with `fresh` at 0 writes 0x70000000 at A-4 first. It then writes zeros downward from A-8 to A-24, and the header 0x1F180000 last at A-28. The result address is A-28.
- R4: A save with `fresh` at 1 writes one zero word. In postincrement mode the word goes to A and the result is A+4. In predecrement mode the word goes to A-4 and the result is A-4.
- R5: A restore whose header bits 31:24 are zero pulses `ctl_clear` once. It writes all NREGS data registers with sign 0, exponent 0x7FFF and an all-ones mantissa. It then sets `fresh` to 1.
- R6: A restore whose header bits 31:24 are nonzero sets `fresh` to 0.
- R7: A restore in postincrement mode returns A+4 plus an extra amount set by header bits 23:16. Code 0x18 adds 24, code 0x38 adds 56 and code 0xB4 adds 180. Any other code, and any empty-frame header, adds nothing.
- R8: A restore in indirect mode (mode 2'b00) reads the header at A and returns A unchanged.
- R9: A pulse on `arith_op` clears `fresh`. The result of a restore takes priority in the same cycle.
- R10: A save in mode 2'b00, a restore in mode 2'b10, or any command in mode 2'b11 ends with `done_err` at 1. Such a command makes no memory request, returns A unchanged and leaves `fresh` as it was.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request (valid, write, address, data) holds stable.
- R12: `cmd_ready` is low from the cycle after a command is accepted until that command finishes. `done_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_restore | input | 1 | 1 = restore, 0 = save |
| cmd_mode | input | 2 | 00 indirect, 01 postincrement, 10 predecrement, 11 reserved |
| cmd_areg | input | AW | Address register value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block takes read data |
| mem_rsp_data | input | 32 | Read data |
| done_valid | output | 1 | Command finished (pulse) |
| done_err | output | 1 | Unsupported mode |
| done_areg | output | AW | Updated address register |
| arith_op | input | 1 | An arithmetic or move operation ran |
| fresh | output | 1 | Unit reinitialised, no operation since |
| ctl_clear | output | 1 | Clear control, status and instruction-address registers |
| rf_we | output | 1 | Data register write |
| rf_waddr | output | $clog2(NREGS) | Data register index |
| rf_wdata | output | 1+EXP_W+MANT_W | Data register value |

## Verification
The bench covers all three postincrement size codes plus an unknown code. A decoder that dropped the 4 header bytes, or applied a size to an empty header, would return an address off by 4 or more. It checks every word address and value of both idle-frame layouts. Swapping the header and trailer in predecrement, or using the wrong starting offset, shows up as a mismatched log entry. The bench also counts memory accesses and register-file writes around unsupported modes and empty-frame restores. A design that touched memory on an error, or skipped a data register, would show the wrong count. Finally, it moves `fresh` through reset, empty-frame restore, non-empty restore and `arith_op`. A save that picked the wrong frame would then write 1 word where 7 were expected, or 7 where 1 was expected.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;
  typedef enum logic [1:0] {
    AM_IND     = 2'b00,
    AM_POSTINC = 2'b01,
    AM_PREDEC  = 2'b10,
    AM_RSVD    = 2'b11
  } am_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_RDREQ, S_RDWAIT, S_INIT, S_DONE
  } st_e;

  localparam logic [31:0] IDLE_HDR   = 32'h1F18_0000;
  localparam logic [31:0] IDLE_TRL   = 32'h7000_0000;
  localparam int          IDLE_WORDS = 7;
  localparam int          WORD_BYTES = 4;

  localparam logic [7:0]  CODE_IDLE  = 8'h18;
  localparam logic [7:0]  CODE_UNIMP = 8'h38;
  localparam logic [7:0]  CODE_BUSY  = 8'hB4;
  localparam int          BYTES_IDLE  = 24;
  localparam int          BYTES_UNIMP = 56;
  localparam int          BYTES_BUSY  = 180;
endpackage

// File: rtl/fpctx_word_gen.sv
module fpctx_word_gen
  import fpctx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 3
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  input  logic             predec,
  input  logic             null_frame,
  output logic [AW-1:0]    addr,
  output logic [31:0]      wdata
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(IDLE_WORDS - 1);

  logic [IDX_W-1:0] pos;
  logic [AW-1:0]    step;

  // byte step of the current word from the frame start
  assign step = AW'({idx, 2'b00});
  assign addr = predec ? (base - AW'(WORD_BYTES) - step) : (base + step);

  // position of this word inside the frame, header at 0
  assign pos = predec ? (LAST - idx) : idx;

  always_comb begin
    if (null_frame)       wdata = '0;
    else if (pos == '0)   wdata = IDLE_HDR;
    else if (pos == LAST) wdata = IDLE_TRL;
    else                  wdata = '0;
  end
endmodule

// File: rtl/fpctx_size_decode.sv
module fpctx_size_decode
  import fpctx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [7:0]    hdr_top,
  input  logic [7:0]    hdr_code,
  output logic          is_null,
  output logic [AW-1:0] extra
);
  assign is_null = (hdr_top == 8'h00);

  always_comb begin
    extra = '0;
    if (!is_null) begin
      unique case (hdr_code)
        CODE_IDLE:  extra = AW'(BYTES_IDLE);
        CODE_UNIMP: extra = AW'(BYTES_UNIMP);
        CODE_BUSY:  extra = AW'(BYTES_BUSY);
        default:    extra = '0;
      endcase
    end
  end
endmodule

// File: rtl/fpctx_rf_init.sv
module fpctx_rf_init #(
  parameter int NREGS  = 8,
  parameter int EXP_W  = 15,
  parameter int MANT_W = 64,
  localparam int RI_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int RW    = 1 + EXP_W + MANT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            rf_we,
  output logic [RI_W-1:0] rf_waddr,
  output logic [RW-1:0]   rf_wdata,
  output logic            ctl_clear,
  output logic            fin
);
  localparam logic [RI_W-1:0] LAST = RI_W'(NREGS - 1);

  logic            active;
  logic [RI_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) active <= 1'b0;
    end
  end

  assign rf_we     = active;
  assign rf_waddr  = cnt;
  assign rf_wdata  = {1'b0, {EXP_W{1'b1}}, {MANT_W{1'b1}}};
  assign ctl_clear = active && (cnt == '0);
  assign fin       = active && (cnt == LAST);

  // R5: the register sweep runs without gaps until the last index
  p_sweep_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_waddr != LAST) |=> rf_we);
endmodule

// File: rtl/fpctx_frame_ctrl.sv
module fpctx_frame_ctrl
  import fpctx_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NREGS  = 8,
  parameter int EXP_W  = 15,
  parameter int MANT_W = 64,
  localparam int RI_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int RW    = 1 + EXP_W + MANT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_restore,
  input  logic [1:0]      cmd_mode,
  input  logic [AW-1:0]   cmd_areg,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [31:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [31:0]     mem_rsp_data,
  output logic            done_valid,
  output logic            done_err,
  output logic [AW-1:0]   done_areg,
  input  logic            arith_op,
  output logic            fresh,
  output logic            ctl_clear,
  output logic            rf_we,
  output logic [RI_W-1:0] rf_waddr,
  output logic [RW-1:0]   rf_wdata
);
  localparam int IDX_W = $clog2(IDLE_WORDS);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(IDLE_WORDS - 1);
  localparam logic [AW-1:0] FRAME_BYTES = AW'(IDLE_WORDS * WORD_BYTES);

  st_e             st;
  am_e             mode_q;
  logic            restore_q;
  logic            null_q;
  logic            hdr_null_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   res_q;
  logic            err_q;
  logic [IDX_W-1:0] idx_q;

  logic            cmd_fire;
  logic            cmd_bad;
  logic [AW-1:0]   gen_addr;
  logic [31:0]     gen_data;
  logic            rsp_null;
  logic [AW-1:0]   rsp_extra;
  logic            rsp_fire;
  logic            init_start;
  logic            init_fin;
  logic            wr_last;
  logic [AW-1:0]   save_span;
  logic            unused_rsp;

  assign unused_rsp = ^mem_rsp_data[15:0];

  assign cmd_ready = (st == S_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign cmd_bad   = (am_e'(cmd_mode) == AM_RSVD)
                   || (!cmd_restore && am_e'(cmd_mode) == AM_IND)
                   || ( cmd_restore && am_e'(cmd_mode) == AM_PREDEC);

  fpctx_word_gen #(.AW(AW), .IDX_W(IDX_W)) u_word_gen (
    .base       (base_q),
    .idx        (idx_q),
    .predec     (mode_q == AM_PREDEC),
    .null_frame (null_q),
    .addr       (gen_addr),
    .wdata      (gen_data)
  );

  fpctx_size_decode #(.AW(AW)) u_size_decode (
    .hdr_top  (mem_rsp_data[31:24]),
    .hdr_code (mem_rsp_data[23:16]),
    .is_null  (rsp_null),
    .extra    (rsp_extra)
  );

  fpctx_rf_init #(.NREGS(NREGS), .EXP_W(EXP_W), .MANT_W(MANT_W)) u_rf_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (init_start),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .ctl_clear (ctl_clear),
    .fin       (init_fin)
  );

  assign mem_req_valid = (st == S_WR) || (st == S_RDREQ);
  assign mem_req_write = (st == S_WR);
  assign mem_req_addr  = (st == S_WR) ? gen_addr : base_q;
  assign mem_req_wdata = (st == S_WR) ? gen_data : '0;
  assign mem_rsp_ready = (st == S_RDWAIT);
  assign rsp_fire      = mem_rsp_valid && mem_rsp_ready;
  assign init_start    = rsp_fire && rsp_null;

  assign wr_last   = null_q ? (idx_q == '0) : (idx_q == LAST_WORD);
  assign save_span = null_q ? AW'(WORD_BYTES) : FRAME_BYTES;

  assign done_valid = (st == S_DONE);
  assign done_err   = err_q;
  assign done_areg  = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mode_q     <= AM_IND;
      restore_q  <= 1'b0;
      null_q     <= 1'b0;
      hdr_null_q <= 1'b0;
      base_q     <= '0;
      res_q      <= '0;
      err_q      <= 1'b0;
      idx_q      <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (cmd_fire) begin
          mode_q     <= am_e'(cmd_mode);
          restore_q  <= cmd_restore;
          base_q     <= cmd_areg;
          res_q      <= cmd_areg;
          idx_q      <= '0;
          null_q     <= fresh;
          hdr_null_q <= 1'b0;
          err_q      <= cmd_bad;
          if (cmd_bad)          st <= S_DONE;
          else if (cmd_restore) st <= S_RDREQ;
          else                  st <= S_WR;
        end
        S_WR: if (mem_req_ready) begin
          if (wr_last) begin
            res_q <= (mode_q == AM_PREDEC) ? (base_q - save_span)
                                           : (base_q + save_span);
            st    <= S_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_RDREQ: if (mem_req_ready) st <= S_RDWAIT;
        S_RDWAIT: if (rsp_fire) begin
          hdr_null_q <= rsp_null;
          if (mode_q == AM_POSTINC)
            res_q <= base_q + AW'(WORD_BYTES) + rsp_extra;
          st <= rsp_null ? S_INIT : S_DONE;
        end
        S_INIT: if (init_fin) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // fresh flag: restore outcome wins over an operation in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     fresh <= 1'b1;
    else if (st == S_INIT && init_fin) fresh <= 1'b1;
    else if (rsp_fire && !rsp_null) fresh <= 1'b0;
    else if (arith_op)              fresh <= 1'b0;
  end

  p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  p_bad_no_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_bad) |=> (!mem_req_valid && done_valid && done_err));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_ready);

  p_null_sets_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && restore_q && !err_q && hdr_null_q) |-> fresh);

  p_hdr_clears_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && restore_q && !err_q && !hdr_null_q) |-> !fresh);
endmodule

// File: tb/fpctx_frame_ctrl_tb.sv
`timescale 1ns/1ps
module fpctx_frame_ctrl_tb;
  localparam int AW = 32;
  localparam int NREGS = 8;
  localparam int RW = 80;

  typedef struct packed {
    logic        rst;
    logic [1:0]  mode;
    logic [31:0] areg;
    logic [31:0] hdr;
    logic [31:0] exp_areg;
    logic        exp_err;
    logic [3:0]  exp_nwr;
    logic        exp_fresh;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b01, 32'h40, 32'h0,         32'h44, 1'b0, 4'd1, 1'b1}, // R4 pi empty
    '{1'b1, 2'b01, 32'h10, 32'h1F18_0000, 32'h2C, 1'b0, 4'd0, 1'b0}, // R6 R7 0x18
    '{1'b0, 2'b01, 32'h40, 32'h0,         32'h5C, 1'b0, 4'd7, 1'b0}, // R2
    '{1'b0, 2'b10, 32'h80, 32'h0,         32'h64, 1'b0, 4'd7, 1'b0}, // R3
    '{1'b1, 2'b01, 32'h10, 32'h1F38_0000, 32'h4C, 1'b0, 4'd0, 1'b0}, // R7 0x38
    '{1'b1, 2'b01, 32'h10, 32'h41B4_0000, 32'hC8, 1'b0, 4'd0, 1'b0}, // R7 0xB4
    '{1'b1, 2'b01, 32'h10, 32'h1F99_0000, 32'h14, 1'b0, 4'd0, 1'b0}, // R7 unknown
    '{1'b1, 2'b00, 32'h20, 32'h1F18_0000, 32'h20, 1'b0, 4'd0, 1'b0}, // R8
    '{1'b0, 2'b00, 32'h50, 32'h0,         32'h50, 1'b1, 4'd0, 1'b0}, // R10
    '{1'b1, 2'b10, 32'h50, 32'h0,         32'h50, 1'b1, 4'd0, 1'b0}, // R10
    '{1'b0, 2'b11, 32'h50, 32'h0,         32'h50, 1'b1, 4'd0, 1'b0}, // R10
    '{1'b1, 2'b00, 32'h30, 32'h00FF_FFFF, 32'h30, 1'b0, 4'd0, 1'b1}, // R5 R8
    '{1'b0, 2'b10, 32'h80, 32'h0,         32'h7C, 1'b0, 4'd1, 1'b1}, // R4 pd empty
    '{1'b1, 2'b01, 32'h10, 32'h0,         32'h14, 1'b0, 4'd0, 1'b1}, // R5 R7 empty
    '{1'b1, 2'b11, 32'h50, 32'h1F18_0000, 32'h50, 1'b1, 4'd0, 1'b1}  // R10 keeps fresh
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            cmd_valid = 1'b0, cmd_ready, cmd_restore = 1'b0;
  logic [1:0]      cmd_mode = 2'b00;
  logic [AW-1:0]   cmd_areg = '0;
  logic            mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0]   mem_req_addr;
  logic [31:0]     mem_req_wdata;
  logic            mem_rsp_valid, mem_rsp_ready;
  logic [31:0]     mem_rsp_data;
  logic            done_valid, done_err;
  logic [AW-1:0]   done_areg;
  logic            arith_op = 1'b0, fresh, ctl_clear, rf_we;
  logic [2:0]      rf_waddr;
  logic [RW-1:0]   rf_wdata;

  fpctx_frame_ctrl #(.AW(AW), .NREGS(NREGS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_restore(cmd_restore),
    .cmd_mode(cmd_mode), .cmd_areg(cmd_areg),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_err(done_err), .done_areg(done_areg),
    .arith_op(arith_op), .fresh(fresh), .ctl_clear(ctl_clear),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // memory model with periodic back-pressure, plus logs
  logic [31:0] mem [0:63];
  logic [3:0]  rdy_ctr;
  logic        pre_we = 1'b0, clr_logs = 1'b0;
  logic [5:0]  pre_idx = '0;
  logic [31:0] pre_val = '0;
  logic [31:0] wlog_addr [0:15];
  logic [31:0] wlog_data [0:15];
  int          wcnt, acc_cnt, rf_cnt, ctl_cnt, rf_bad;

  always @(posedge clk) begin
    if (!rst_n) begin
      rdy_ctr <= '0; mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      wcnt <= 0; acc_cnt <= 0; rf_cnt <= 0; ctl_cnt <= 0; rf_bad <= 0;
    end else begin
      rdy_ctr       <= rdy_ctr + 1'b1;
      mem_req_ready <= (rdy_ctr[1:0] != 2'b01);
      if (pre_we) mem[pre_idx] <= pre_val;
      if (clr_logs) begin
        wcnt <= 0; acc_cnt <= 0; rf_cnt <= 0; ctl_cnt <= 0; rf_bad <= 0;
      end else begin
        if (mem_req_valid && mem_req_ready) begin
          acc_cnt <= acc_cnt + 1;
          if (mem_req_write) begin
            mem[mem_req_addr[7:2]] <= mem_req_wdata;
            if (wcnt < 16) begin
              wlog_addr[wcnt] <= mem_req_addr;
              wlog_data[wcnt] <= mem_req_wdata;
            end
            wcnt <= wcnt + 1;
          end
        end
        if (rf_we) begin
          rf_cnt <= rf_cnt + 1;
          if (rf_wdata != {1'b0, 15'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF} ||
              rf_waddr != 3'(rf_cnt)) rf_bad <= rf_bad + 1;
        end
        if (ctl_clear) ctl_cnt <= ctl_cnt + 1;
      end
      if (mem_req_valid && mem_req_ready && !mem_req_write) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[7:2]];
      end else if (mem_rsp_valid && mem_rsp_ready) begin
        mem_rsp_valid <= 1'b0;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prep(input logic [31:0] addr, input logic [31:0] val);
    @(negedge clk);
    pre_we = 1'b1; pre_idx = addr[7:2]; pre_val = val; clr_logs = 1'b1;
    @(negedge clk);
    pre_we = 1'b0; clr_logs = 1'b0;
  endtask

  logic [31:0] r_areg;
  logic        r_err;

  task automatic run_cmd(input logic rs, input logic [1:0] md, input logic [31:0] a);
    int guard = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_restore = rs; cmd_mode = md; cmd_areg = a;
    while (!cmd_ready && guard < 300) begin @(negedge clk); guard++; end
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done_valid && guard < 300) begin @(negedge clk); guard++; end
    if (guard >= 300) chk(1'b0, "R12 watchdog", 32'(guard), 32'd300);
    r_areg = done_areg;
    r_err  = done_err;
    @(negedge clk);
  endtask

  function automatic logic [31:0] frame_word(input int pos);
    if (pos == 0) return 32'h1F18_0000;
    if (pos == 6) return 32'h7000_0000;
    return 32'h0;
  endfunction

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fresh == 1'b1, "R1 fresh", 32'(fresh), 32'd1);
    chk(cmd_ready == 1'b1 && done_valid == 1'b0, "R1 ready/done",
        {30'd0, cmd_ready, done_valid}, 32'd2);
    chk(!mem_req_valid && !rf_we && !ctl_clear, "R1 quiet",
        {29'd0, mem_req_valid, rf_we, ctl_clear}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      int   exp_acc;
      int   bad = 0;
      prep(t.areg, t.hdr);
      run_cmd(t.rst, t.mode, t.areg);
      chk(r_areg == t.exp_areg, "R2 R3 R4 R7 R8 R10 areg", r_areg, t.exp_areg);
      chk(r_err == t.exp_err, "R10 err", 32'(r_err), 32'(t.exp_err));
      chk(wcnt == int'(t.exp_nwr), "R2 R3 R4 write count", 32'(wcnt), 32'(t.exp_nwr));
      chk(fresh == t.exp_fresh, "R5 R6 R10 fresh", 32'(fresh), 32'(t.exp_fresh));
      exp_acc = int'(t.exp_nwr) + ((t.rst && !t.exp_err) ? 1 : 0);
      chk(acc_cnt == exp_acc, "R10 access count", 32'(acc_cnt), 32'(exp_acc));
      if (t.rst && !t.exp_err && t.hdr[31:24] == 8'h00) begin
        chk(rf_cnt == NREGS && rf_bad == 0, "R5 register sweep", 32'(rf_cnt), 32'(NREGS));
        chk(ctl_cnt == 1, "R5 ctl_clear", 32'(ctl_cnt), 32'd1);
      end else begin
        chk(rf_cnt == 0 && ctl_cnt == 0, "R5 no init", 32'(rf_cnt + ctl_cnt), 32'd0);
      end
      for (int i = 0; i < int'(t.exp_nwr) && i < 16; i++) begin
        logic [31:0] ea = (t.mode == 2'b01) ? t.areg + 32'(4 * i) : t.areg - 32'(4 + 4 * i);
        logic [31:0] ed = (t.exp_nwr == 4'd1) ? 32'h0
                        : frame_word((t.mode == 2'b01) ? i : 6 - i);
        if (wlog_addr[i] != ea || wlog_data[i] != ed) begin
          bad++;
          $display("FAIL R2 R3 R4 word %0d actual=%h:%h expected=%h:%h",
                   i, wlog_addr[i], wlog_data[i], ea, ed);
        end
      end
      if (t.exp_nwr != 0) chk(bad == 0, "R2 R3 R4 frame contents", 32'(bad), 32'd0);
    end

    // R9: an operation clears fresh, so the next save writes the idle frame
    @(negedge clk); arith_op = 1'b1;
    @(negedge clk); arith_op = 1'b0;
    chk(fresh == 1'b0, "R9 arith clears fresh", 32'(fresh), 32'd0);
    prep(32'h40, 32'h0);
    run_cmd(1'b0, 2'b01, 32'h40);
    chk(wcnt == 7, "R9 idle frame after op", 32'(wcnt), 32'd7);
    chk(r_areg == 32'h5C, "R9 R2 areg", r_areg, 32'h5C);

    // R12: command held while busy is not re-accepted; ready returns after done
    chk(cmd_ready == 1'b1, "R12 ready after done", 32'(cmd_ready), 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule